// File: doc/BRIEF.md
# Modem Control and Status Register Pair with Loopback

This block keeps the modem control byte and the modem status byte of a 16550-style serial controller. The host reaches both through a single write/read strobe pair, a 3-bit register offset and a data byte. Control offset 4 is writable. Status offset 6 is read-only, and reading it has a side effect.

In loopback mode the control outputs are routed back into the four status levels. Outside loopback those levels are held at zero, because the physical modem pins are treated as inactive. Whenever the levels are recomputed, the block records each change in sticky change (delta) bits. A single pending output shows that at least one delta is set, and the interrupt logic uses it. A status read returns the current byte and clears the deltas.

Top module: `mdm_ctl_stat`

## Requirements
- R1: A control write (`wr_i` at offset 4) stores `wdata_i[4:0]`. A control read returns that value with bits 7:5 at zero. The control bit fields are DTR bit 0, RTS bit 1, OUT1 bit 2, OUT2 bit 3 and LOOP bit 4.
- R2: While LOOP is set, the status levels take their values from the control bits: CTS (status bit 4) from RTS, DSR (bit 5) from DTR, RI (bit 6) from OUT1 and DCD (bit 7) from OUT2.
- R3: While LOOP is clear, status bits 7:4 read as zero.
- R4: A control write that changes the level of CTS, DSR or DCD sets that signal's delta bit: CTS at bit 0, DSR at bit 1, DCD at bit 3.
- R5: The ring delta (status bit 2) is set only when RI goes from 1 to 0. A rising RI leaves it unchanged.
- R6: Deltas already set stay set across later control writes. Only status bits 7:4 are replaced.
- R7: A status read (`rd_i` at offset 6) returns the current status byte in the same cycle. All four delta bits are zero from the next cycle on.
- R8: A write at offset 6 changes neither the status byte nor the control byte.
- R9: `delta_pend_o` is high exactly when at least one of status bits 3:0 is set.
- R10: A control write that leaves all four levels unchanged sets no delta bit.
- R11: After reset, both bytes read as zero and `delta_pend_o` is low. A read at any offset other than 4 or 6, or a cycle with no read, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the strobe and offset |
| delta_pend_o | output | 1 | At least one delta bit is set |

## Verification
Directed control values exercise each loopback route alone. The sequences include turning LOOP on with all outputs high, dropping OUT1 on its own and raising it again, and disabling loopback. Together these separate the swapped RTS/CTS and DTR/DSR routing from a straight mapping, and the falling-only ring delta from an any-edge one. Repeated identical writes, status writes and back-to-back status reads show sticky deltas, no spurious deltas, and clear-after-read timing. A long pseudo-random mix of offsets and data is then compared against a behavioural model on every clock.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  parameter int unsigned AW       = 3;
  parameter int unsigned DW       = 8;
  parameter int unsigned CTRL_W   = 5;
  parameter logic [AW-1:0] CTRL_OFS = 3'd4;
  parameter logic [AW-1:0] STAT_OFS = 3'd6;

  // control field positions
  localparam int unsigned C_DTR  = 0;
  localparam int unsigned C_RTS  = 1;
  localparam int unsigned C_OUT1 = 2;
  localparam int unsigned C_OUT2 = 3;
  localparam int unsigned C_LOOP = 4;

  // status upper nibble, MSB first: bit7..bit4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lvl_t;

  // status lower nibble, MSB first: bit3..bit0
  typedef struct packed {
    logic d_dcd;
    logic ri_fall;
    logic d_dsr;
    logic d_cts;
  } mdm_dlt_t;
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
#(
  parameter int unsigned W = CTRL_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_o <= '0;
    else if (wr_en_i) ctrl_o <= wdata_i;
  end

  AST_CTRL_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctrl_o == $past(wdata_i)); // R1

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_o)); // R8
endmodule

// File: rtl/mdm_loop_map.sv
module mdm_loop_map
  import mdm_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output mdm_lvl_t          lvl_o
);
  always_comb begin
    lvl_o = '0;
    if (ctrl_i[C_LOOP]) begin
      lvl_o.cts = ctrl_i[C_RTS];
      lvl_o.dsr = ctrl_i[C_DTR];
      lvl_o.ri  = ctrl_i[C_OUT1];
      lvl_o.dcd = ctrl_i[C_OUT2];
    end
  end
endmodule

// File: rtl/mdm_delta_track.sv
module mdm_delta_track
  import mdm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     upd_i,
  input  mdm_lvl_t new_lvl_i,
  input  logic     clr_i,
  output mdm_lvl_t lvl_o,
  output mdm_dlt_t dlt_o
);
  mdm_dlt_t set_d;

  always_comb begin
    set_d         = '0;
    set_d.d_cts   = new_lvl_i.cts ^ lvl_o.cts;
    set_d.d_dsr   = new_lvl_i.dsr ^ lvl_o.dsr;
    set_d.d_dcd   = new_lvl_i.dcd ^ lvl_o.dcd;
    set_d.ri_fall = lvl_o.ri & ~new_lvl_i.ri;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o <= '0;
      dlt_o <= '0;
    end else if (upd_i) begin
      lvl_o <= new_lvl_i;
      dlt_o <= dlt_o | set_d;
    end else if (clr_i) begin
      dlt_o <= '0;
    end
  end

  AST_CTS_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (new_lvl_i.cts != lvl_o.cts)) |=> dlt_o.d_cts); // R4

  AST_DCD_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (new_lvl_i.dcd != lvl_o.dcd)) |=> dlt_o.d_dcd); // R4

  AST_RI_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dlt_o.ri_fall) |-> ($past(lvl_o.ri) && !lvl_o.ri)); // R5

  AST_DELTA_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i) |=> ((dlt_o & $past(dlt_o)) == $past(dlt_o))); // R6

  AST_DELTA_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !upd_i) |=> dlt_o == '0); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i && new_lvl_i == lvl_o) |=> $stable(dlt_o)); // R10
endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
  import mdm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          delta_pend_o
);
  localparam int unsigned PADW = DW - CTRL_W;

  logic              ctrl_wr, stat_rd;
  logic [CTRL_W-1:0] ctrl_q;
  mdm_lvl_t          lvl_next, lvl_q;
  mdm_dlt_t          dlt_q;

  assign ctrl_wr = wr_i & (addr_i == CTRL_OFS);
  assign stat_rd = rd_i & (addr_i == STAT_OFS);

  mdm_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (ctrl_wr),
    .wdata_i (wdata_i[CTRL_W-1:0]),
    .ctrl_o  (ctrl_q)
  );

  // levels follow the value being written, so they update with the register
  mdm_loop_map u_map (
    .ctrl_i (wdata_i[CTRL_W-1:0]),
    .lvl_o  (lvl_next)
  );

  mdm_delta_track u_dlt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (ctrl_wr),
    .new_lvl_i (lvl_next),
    .clr_i     (stat_rd),
    .lvl_o     (lvl_q),
    .dlt_o     (dlt_q)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == CTRL_OFS)      rdata_o = {{PADW{1'b0}}, ctrl_q};
      else if (addr_i == STAT_OFS) rdata_o = {lvl_q, dlt_q};
    end
  end

  assign delta_pend_o = |dlt_q;

  AST_LOOP_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[C_LOOP] |-> (lvl_q.cts == ctrl_q[C_RTS] && lvl_q.dsr == ctrl_q[C_DTR]
                        && lvl_q.ri == ctrl_q[C_OUT1] && lvl_q.dcd == ctrl_q[C_OUT2])); // R2

  AST_NOLOOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[C_LOOP] |-> lvl_q == '0); // R3

  AST_STAT_WR_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == STAT_OFS && !rd_i) |=> ($stable(lvl_q) && $stable(dlt_q))); // R8
endmodule

// File: tb/mdm_ctl_stat_test.sv
module mdm_ctl_stat_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       delta_pend_o;

  int checks = 0, failures = 0;
  int m_ctrl = 0;   // model control byte
  int m_stat = 0;   // model status byte

  always #10 clk = ~clk;

  mdm_ctl_stat uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .delta_pend_o(delta_pend_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic int lvl_of(input int c);
    int r = 0;
    if (c & 16) begin
      if (c & 2) r |= 8'h10;  // RTS -> CTS
      if (c & 1) r |= 8'h20;  // DTR -> DSR
      if (c & 4) r |= 8'h40;  // OUT1 -> RI
      if (c & 8) r |= 8'h80;  // OUT2 -> DCD
    end
    return r;
  endfunction

  // one bus cycle: drive after negedge, compare combinational outputs, advance model
  task automatic cyc(input bit w, input bit r, input int a, input int d, input string req);
    int exp_rd, nl, ol, dl;
    @(negedge clk);
    wr_i = w; rd_i = r; addr_i = a[2:0]; wdata_i = d[7:0];
    #1;
    exp_rd = 0;
    if (r && a == 4) exp_rd = m_ctrl;
    if (r && a == 6) exp_rd = m_stat;
    chk(req, rdata_o, exp_rd);
    chk("R9", delta_pend_o, (m_stat & 15) != 0);
    @(posedge clk);
    if (w && a == 4) begin
      m_ctrl = d & 31;
      nl = lvl_of(m_ctrl);
      ol = m_stat & 8'hF0;
      dl = m_stat & 15;
      if ((nl ^ ol) & 8'h10) dl |= 1;
      if ((nl ^ ol) & 8'h20) dl |= 2;
      if ((nl ^ ol) & 8'h80) dl |= 8;
      if ((ol & 8'h40) && !(nl & 8'h40)) dl |= 4;
      m_stat = nl | dl;
    end else if (r && a == 6) begin
      m_stat = m_stat & 8'hF0;
    end
  endtask

  initial begin
    int lfsr;
    #2000000;
    failures++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lfsr;
    repeat (3) @(posedge clk);
    #3 rst_ni = 1'b1;
    // R11 reset state
    cyc(0, 1, 4, 0, "R11");
    cyc(0, 1, 6, 0, "R11");
    cyc(0, 0, 6, 0, "R11");
    cyc(0, 1, 2, 0, "R11");
    // R1 upper bits masked, loop enable all high
    cyc(1, 0, 4, 8'hFF, "R1");
    cyc(0, 1, 4, 0, "R1");
    chk("R1", rdata_o, 8'h1F);
    cyc(0, 1, 6, 0, "R2");    // levels F0, deltas CTS/DSR/DCD -> FB
    chk("R4", rdata_o, 8'hFB);
    cyc(0, 1, 6, 0, "R7");    // cleared
    chk("R7", rdata_o, 8'hF0);
    // drop OUT1 only: ring falls
    cyc(1, 0, 4, 8'h1B, "R5");
    cyc(0, 1, 6, 0, "R5");
    chk("R5", rdata_o, 8'hB4);
    // raise OUT1 again: no ring delta
    cyc(1, 0, 4, 8'h1F, "R5");
    cyc(0, 1, 6, 0, "R5");
    chk("R5", rdata_o, 8'hF0);
    // same value: no delta
    cyc(1, 0, 4, 8'h1F, "R10");
    cyc(0, 0, 0, 0, "R10");
    chk("R10", delta_pend_o, 0);
    // status write ignored
    cyc(1, 0, 6, 8'h0F, "R8");
    cyc(0, 1, 6, 0, "R8");
    chk("R8", rdata_o, 8'hF0);
    cyc(0, 1, 4, 0, "R8");
    chk("R8", rdata_o, 8'h1F);
    // RTS alone in loop -> CTS; then DTR alone -> DSR (sticky across writes)
    cyc(1, 0, 4, 8'h12, "R2");
    cyc(1, 0, 4, 8'h11, "R6");
    cyc(0, 1, 6, 0, "R6");
    chk("R6", rdata_o, 8'h2F);
    // loop off: all levels zero
    cyc(1, 0, 4, 8'h0F, "R3");
    cyc(0, 1, 6, 0, "R3");
    chk("R3", rdata_o, 8'h02);
    // random mix, model compared each cycle
    lfsr = 32'h1ACE5;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr == 0) lfsr = 1;
      cyc(lfsr[0], lfsr[1], (lfsr[2] ? (lfsr[3] ? 6 : 4) : lfsr[6:4]),
          lfsr[15:8], "R2");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule